// File: doc/BRIEF.md
# Real-Time Clock with Published Counters and Coherent Seconds Capture

This block is a real-time clock that sits on a simple 32-bit register bus. It runs entirely in the bus clock domain. A one-cycle `tick_en` strobe marks each period of the slow reference clock. From that strobe a fractional accumulator derives a milliseconds counter, and each milliseconds wrap advances a 32-bit seconds counter. The bus does not read the live counters. It reads a published copy, which the block refreshes once every `COPY_TICKS` reference ticks. While that refresh is under way, the block raises a busy flag that software can poll.

Reading the milliseconds register also latches the published seconds into a separate capture register. A read of that capture register right afterwards therefore returns seconds that belong with the milliseconds just read. The block has five interrupt sources:

- two seconds-match alarms;
- one milliseconds-match alarm;
- a seconds countdown;
- a milliseconds countdown.

Each source has a write-1-to-clear status bit and an enable bit. The interrupt output is a level that stays high while any enabled status bit is set. Software follows one rule: wait for the busy flag to drop, then write. Writes that arrive while the block is busy are lost.

Top module: `bus_rtc`

## Requirements
- R1: After synchronous reset, the following all read 0: the seconds, milliseconds, capture, alarm, countdown, enable and status registers. The busy bit reads 0 and `irq` is low.
- R2: Every `COPY_TICKS`-th tick, the busy bit (bit 0 at offset 0x04) rises and stays high for exactly `COPY_CYC` bus cycles. When it falls, the seconds register (0x08) and milliseconds register (0x10) take the live counter values.
- R3: A write of any register is discarded if it arrives while busy is high. A write that arrives while busy is low takes effect at that clock edge.
- R4: A read of offset 0x10 copies the published seconds into the capture register (0x0C). The capture register keeps that value until the next read of 0x10.
- R5: The status register (0x2C) and the enable register (0x28) use these bit positions: bit 0 is seconds alarm A, bit 1 is seconds alarm B, bit 2 is the milliseconds alarm, bit 3 is the seconds countdown and bit 4 is the milliseconds countdown. Higher bits read 0.
- R6: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged. Only such a write can clear a status bit.
- R7: `irq` is high exactly while some status bit and its enable bit are both 1.
- R8: The milliseconds counter runs from 0 to `MS_PER_SEC-1`. Each tick adds `MS_PER_SEC` to an accumulator, and each time the accumulator reaches `TICK_HZ` the counter steps once. When the counter wraps, seconds increment, and seconds roll over from 0xFFFFFFFF to 0.
- R9: A seconds alarm (A at 0x14, B at 0x18) sets its status bit when a counter step makes the seconds equal to the alarm value. The milliseconds alarm (0x1C) works the same way against the milliseconds counter. An alarm register that holds 0 never fires.
- R10: An accepted write of seconds loads the live and published seconds immediately. It also zeroes the milliseconds counter, its published copy and the accumulator.
- R11: A countdown (seconds at 0x20, milliseconds at 0x24) loads the written value. It then decrements once per seconds or milliseconds step. When it reaches 0 it sets its status bit and stops.
- R12: The seconds alarms read back all 32 bits. The milliseconds alarm reads back its low `MS_W` bits. The enable register reads back its low 5 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe per reference-clock period |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the next edge |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, high while an enabled status bit is set |

## Verification
The checker module watches several properties on every cycle:

- the busy window lasts exactly `COPY_CYC` cycles;
- the enable register holds still under writes that arrive while busy;
- the capture register takes the published seconds on each milliseconds read;
- a status bit falls only after an accepted clear write;
- a zero alarm never raises its bit;
- `irq` is never high with all enables off;
- the published milliseconds stay in range.

Other behaviour takes the bench's timed scenarios to show:

- the spacing between copies;
- the capture register holding its value while the seconds move on;
- the seconds rollover;
- an alarm that fires on the right second and not before;
- countdown expiry;
- the interplay of enable and clear on `irq`.

// File: rtl/bus_rtc_pkg.sv
// Shared register offsets, interrupt source indices and strobe types for
// the bus RTC. Assumes byte offsets on an 8-bit address bus.
package bus_rtc_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int NUM_SRC = 5;

    // Interrupt source bit positions (status and enable share them)
    localparam int SRC_SEC_A = 0;
    localparam int SRC_SEC_B = 1;
    localparam int SRC_MS    = 2;
    localparam int SRC_CD_S  = 3;
    localparam int SRC_CD_MS = 4;

    // Register byte offsets
    localparam logic [ADDR_W-1:0] OFF_BUSY  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_SEC   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_CAPT  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_MS    = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_ALA   = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_ALB   = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_ALMS  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_CDS   = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_CDMS  = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_EN    = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h2C;

    // Write strobes aimed at the alarm/countdown unit
    typedef struct packed {
        logic ala;
        logic alb;
        logic alms;
        logic cds;
        logic cdms;
    } alarm_wr_t;

endpackage

// File: rtl/bus_rtc_timebase.sv
// Time base: fractional accumulator -> milliseconds -> seconds, plus the
// periodic publish window with its busy flag.
// Assumes tick_en is already synchronous to clk, lasts one cycle, and that
// ticks are further apart than COPY_CYC cycles. MS_PER_SEC <= TICK_HZ.
module bus_rtc_timebase #(
    parameter int TICK_HZ    = 32768,
    parameter int MS_PER_SEC = 1000,
    parameter int COPY_TICKS = 8,
    parameter int COPY_CYC   = 4,
    parameter int MS_W       = 10,
    parameter int ACC_W      = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            sec_load,
    input  logic [31:0]     sec_load_val,
    output logic            busy,
    output logic [31:0]     live_sec,
    output logic [MS_W-1:0] live_ms,
    output logic            sec_evt,
    output logic            ms_evt,
    output logic [31:0]     pub_sec,
    output logic [MS_W-1:0] pub_ms
);

    localparam int PH_W = (COPY_TICKS > 1) ? $clog2(COPY_TICKS) : 1;
    localparam int BC_W = $clog2(COPY_CYC) + 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;
    logic             ms_due;
    logic             ms_wrap;
    logic [PH_W-1:0]  phase;
    logic             copy_start;
    logic [BC_W-1:0]  bcnt;

    // Next accumulator value and whether a millisecond step is owed
    always_comb begin
        acc_sum = acc + ACC_W'(MS_PER_SEC);
        ms_due  = (acc_sum >= ACC_W'(TICK_HZ));
        ms_wrap = (live_ms == MS_W'(MS_PER_SEC - 1));
    end

    // Live counters: a seconds load wins over a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            live_ms  <= '0;
            live_sec <= '0;
        end else if (sec_load) begin
            acc      <= '0;
            live_ms  <= '0;
            live_sec <= sec_load_val;
        end else if (tick_en) begin
            acc <= ms_due ? (acc_sum - ACC_W'(TICK_HZ)) : acc_sum;
            if (ms_due) begin
                live_ms <= ms_wrap ? '0 : live_ms + 1'b1;
                if (ms_wrap) begin
                    live_sec <= live_sec + 32'd1;
                end
            end
        end
    end

    // Step events, aligned with the counter values they produced
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_evt <= 1'b0;
            ms_evt  <= 1'b0;
        end else begin
            sec_evt <= !sec_load && tick_en && ms_due && ms_wrap;
            ms_evt  <= !sec_load && tick_en && ms_due;
        end
    end

    // Tick phase within one publish period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (tick_en) begin
            phase <= (phase == PH_W'(COPY_TICKS - 1)) ? '0 : phase + 1'b1;
        end
    end

    assign copy_start = tick_en && (phase == PH_W'(COPY_TICKS - 1));

    // Busy window of COPY_CYC cycles opened by the last tick of a period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            bcnt <= '0;
        end else if (!busy && copy_start) begin
            busy <= 1'b1;
            bcnt <= BC_W'(COPY_CYC - 1);
        end else if (busy) begin
            if (bcnt == '0) begin
                busy <= 1'b0;
            end else begin
                bcnt <= bcnt - 1'b1;
            end
        end
    end

    // Published copy: refreshed as the window closes, or by a seconds load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pub_sec <= '0;
            pub_ms  <= '0;
        end else if (sec_load) begin
            pub_sec <= sec_load_val;
            pub_ms  <= '0;
        end else if (busy && (bcnt == '0)) begin
            pub_sec <= live_sec;
            pub_ms  <= live_ms;
        end
    end

endmodule

// File: rtl/bus_rtc_alarms.sv
// Alarm and countdown unit: holds the match registers and the two one-shot
// countdowns, and produces one fire pulse per interrupt source.
// Assumes sec_evt/ms_evt are high in the cycle right after the counters
// stepped, so live_sec/live_ms already show the new values.
module bus_rtc_alarms
    import bus_rtc_pkg::*;
#(
    parameter int MS_W = 10,
    parameter int CD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  alarm_wr_t          wr,
    input  logic [31:0]        wdata,
    input  logic               sec_evt,
    input  logic               ms_evt,
    input  logic [31:0]        live_sec,
    input  logic [MS_W-1:0]    live_ms,
    output logic [31:0]        ala,
    output logic [31:0]        alb,
    output logic [MS_W-1:0]    alms,
    output logic [CD_W-1:0]    cd_sec,
    output logic [CD_W-1:0]    cd_ms,
    output logic [NUM_SRC-1:0] fire
);

    // Match registers, written only through accepted strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ala  <= '0;
            alb  <= '0;
            alms <= '0;
        end else begin
            if (wr.ala)  ala  <= wdata;
            if (wr.alb)  alb  <= wdata;
            if (wr.alms) alms <= wdata[MS_W-1:0];
        end
    end

    // Seconds countdown: load, then count down to zero and stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cd_sec <= '0;
        end else if (wr.cds) begin
            cd_sec <= wdata[CD_W-1:0];
        end else if (sec_evt && (cd_sec != '0)) begin
            cd_sec <= cd_sec - 1'b1;
        end
    end

    // Milliseconds countdown: load, then count down to zero and stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cd_ms <= '0;
        end else if (wr.cdms) begin
            cd_ms <= wdata[CD_W-1:0];
        end else if (ms_evt && (cd_ms != '0)) begin
            cd_ms <= cd_ms - 1'b1;
        end
    end

    // Fire pulses; a zero alarm register never matches
    always_comb begin
        fire            = '0;
        fire[SRC_SEC_A] = sec_evt && (ala != '0) && (live_sec == ala);
        fire[SRC_SEC_B] = sec_evt && (alb != '0) && (live_sec == alb);
        fire[SRC_MS]    = ms_evt && (alms != '0) && (live_ms == alms);
        fire[SRC_CD_S]  = sec_evt && !wr.cds && (cd_sec == CD_W'(1));
        fire[SRC_CD_MS] = ms_evt && !wr.cdms && (cd_ms == CD_W'(1));
    end

endmodule

// File: rtl/bus_rtc_status.sv
// Interrupt status (sticky, write-1-to-clear), enable register and the
// level interrupt output. A fire pulse wins over a clear in the same cycle.
module bus_rtc_status #(
    parameter int NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] fire,
    input  logic            en_wr,
    input  logic            stat_wr,
    input  logic [NSRC-1:0] wdata,
    output logic [NSRC-1:0] en,
    output logic [NSRC-1:0] status,
    output logic            irq
);

    // Enable register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else if (en_wr) begin
            en <= wdata;
        end
    end

    // One sticky status flop per source
    for (genvar i = 0; i < NSRC; i++) begin : g_stat
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status[i] <= 1'b0;
            end else if (fire[i]) begin
                status[i] <= 1'b1;
            end else if (stat_wr && wdata[i]) begin
                status[i] <= 1'b0;
            end
        end
    end

    // Level interrupt from enabled pending sources
    assign irq = |(status & en);

endmodule

// File: rtl/bus_rtc.sv
// Bus RTC top: register decode, write gating by busy, seconds capture on a
// milliseconds read, and the registered read mux.
// Assumes at most one of bus_rd/bus_wr per cycle and a tick_en synchronous to clk.
module bus_rtc
    import bus_rtc_pkg::*;
#(
    parameter int TICK_HZ    = 32768,
    parameter int MS_PER_SEC = 1000,
    parameter int COPY_TICKS = 8,
    parameter int COPY_CYC   = 4,
    parameter int CD_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int MS_W  = $clog2(MS_PER_SEC);
    localparam int ACC_W = $clog2(TICK_HZ + MS_PER_SEC) + 1;

    logic               busy;
    logic               wr_ok;
    logic               sec_wr;
    logic               en_wr;
    logic               stat_wr;
    alarm_wr_t          al_wr;
    logic [31:0]        live_sec;
    logic [MS_W-1:0]    live_ms;
    logic               sec_evt;
    logic               ms_evt;
    logic [31:0]        pub_sec;
    logic [MS_W-1:0]    pub_ms;
    logic [31:0]        shadow_sec;
    logic [31:0]        ala;
    logic [31:0]        alb;
    logic [MS_W-1:0]    alms;
    logic [CD_W-1:0]    cd_sec;
    logic [CD_W-1:0]    cd_ms;
    logic [NUM_SRC-1:0] fire;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] status;
    logic [DATA_W-1:0]  rd_mux;

    assign wr_ok = bus_wr && !busy;

    // Write decode, gated off while the publish window is open
    always_comb begin
        sec_wr  = 1'b0;
        en_wr   = 1'b0;
        stat_wr = 1'b0;
        al_wr   = '0;
        if (wr_ok) begin
            case (bus_addr)
                OFF_SEC:  sec_wr     = 1'b1;
                OFF_ALA:  al_wr.ala  = 1'b1;
                OFF_ALB:  al_wr.alb  = 1'b1;
                OFF_ALMS: al_wr.alms = 1'b1;
                OFF_CDS:  al_wr.cds  = 1'b1;
                OFF_CDMS: al_wr.cdms = 1'b1;
                OFF_EN:   en_wr      = 1'b1;
                OFF_STAT: stat_wr    = 1'b1;
                default:  ;
            endcase
        end
    end

    bus_rtc_timebase #(
        .TICK_HZ    (TICK_HZ),
        .MS_PER_SEC (MS_PER_SEC),
        .COPY_TICKS (COPY_TICKS),
        .COPY_CYC   (COPY_CYC),
        .MS_W       (MS_W),
        .ACC_W      (ACC_W)
    ) u_timebase (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .sec_load     (sec_wr),
        .sec_load_val (bus_wdata),
        .busy         (busy),
        .live_sec     (live_sec),
        .live_ms      (live_ms),
        .sec_evt      (sec_evt),
        .ms_evt       (ms_evt),
        .pub_sec      (pub_sec),
        .pub_ms       (pub_ms)
    );

    bus_rtc_alarms #(
        .MS_W (MS_W),
        .CD_W (CD_W)
    ) u_alarms (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (al_wr),
        .wdata    (bus_wdata),
        .sec_evt  (sec_evt),
        .ms_evt   (ms_evt),
        .live_sec (live_sec),
        .live_ms  (live_ms),
        .ala      (ala),
        .alb      (alb),
        .alms     (alms),
        .cd_sec   (cd_sec),
        .cd_ms    (cd_ms),
        .fire     (fire)
    );

    bus_rtc_status #(
        .NSRC (NUM_SRC)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .en_wr   (en_wr),
        .stat_wr (stat_wr),
        .wdata   (bus_wdata[NUM_SRC-1:0]),
        .en      (mask),
        .status  (status),
        .irq     (irq)
    );

    // Seconds capture taken by every milliseconds read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_sec <= '0;
        end else if (bus_rd && (bus_addr == OFF_MS)) begin
            shadow_sec <= pub_sec;
        end
    end

    // Read data selection
    always_comb begin
        case (bus_addr)
            OFF_BUSY: rd_mux = {{(DATA_W-1){1'b0}}, busy};
            OFF_SEC:  rd_mux = pub_sec;
            OFF_CAPT: rd_mux = shadow_sec;
            OFF_MS:   rd_mux = {{(DATA_W-MS_W){1'b0}}, pub_ms};
            OFF_ALA:  rd_mux = ala;
            OFF_ALB:  rd_mux = alb;
            OFF_ALMS: rd_mux = {{(DATA_W-MS_W){1'b0}}, alms};
            OFF_CDS:  rd_mux = {{(DATA_W-CD_W){1'b0}}, cd_sec};
            OFF_CDMS: rd_mux = {{(DATA_W-CD_W){1'b0}}, cd_ms};
            OFF_EN:   rd_mux = {{(DATA_W-NUM_SRC){1'b0}}, mask};
            OFF_STAT: rd_mux = {{(DATA_W-NUM_SRC){1'b0}}, status};
            default:  rd_mux = '0;
        endcase
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/bus_rtc_chk.sv
// Property checker for bus_rtc, attached by bind below.
module bus_rtc_chk
    import bus_rtc_pkg::*;
#(
    parameter int COPY_CYC   = 4,
    parameter int MS_PER_SEC = 1000,
    parameter int MS_W       = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NUM_SRC-1:0] mask,
    input logic [NUM_SRC-1:0] status,
    input logic [31:0]        shadow_sec,
    input logic [31:0]        pub_sec,
    input logic [MS_W-1:0]    pub_ms,
    input logic [31:0]        ala,
    input logic               irq
);

    logic [31:0] busy_run;

    // Consecutive busy cycles seen so far
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (busy) begin
            busy_run <= busy_run + 32'd1;
        end else begin
            busy_run <= '0;
        end
    end

    AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < 32'(COPY_CYC))); // R2
    AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(busy_run) == 32'(COPY_CYC - 1))); // R2
    AST_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && (bus_addr == OFF_EN)) |=> $stable(mask)); // R3
    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == OFF_MS)) |=> (shadow_sec == $past(pub_sec))); // R4
    AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status) & ~status)) |->
            $past(bus_wr && !busy && (bus_addr == OFF_STAT))); // R6
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask != '0)); // R7
    AST_MS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, pub_ms} < (MS_W+1)'(MS_PER_SEC))); // R8
    AST_ZERO_ALARM_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[SRC_SEC_A]) |-> ($past(ala) != '0)); // R9

endmodule

bind bus_rtc bus_rtc_chk #(
    .COPY_CYC   (COPY_CYC),
    .MS_PER_SEC (MS_PER_SEC),
    .MS_W       (MS_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .mask       (mask),
    .status     (status),
    .shadow_sec (shadow_sec),
    .pub_sec    (pub_sec),
    .pub_ms     (pub_ms),
    .ala        (ala),
    .irq        (irq)
);

// File: tb/bus_rtc_bench.sv
// Bench for bus_rtc with a scaled tick ratio:
//   tick every 10 cycles, ms step every 2 ticks, 10 ms per second,
//   publish every 8 ticks (80 cycles), busy window 3 cycles.
module bus_rtc_bench;
    import bus_rtc_pkg::*;

    localparam int TICK_HZ    = 20;
    localparam int MS_PER_SEC = 10;
    localparam int COPY_TICKS = 8;
    localparam int COPY_CYC   = 3;
    localparam int CD_W       = 16;
    localparam int TICK_GAP   = 10;
    localparam int NVEC       = 9;

    // {offset, write data, expected readback}
    localparam logic [71:0] VECS [0:NVEC-1] = '{
        {OFF_ALA,  32'h1234_5678, 32'h1234_5678},
        {OFF_ALB,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
        {OFF_ALMS, 32'h0000_FFFF, 32'h0000_000F},
        {OFF_EN,   32'hFFFF_FFE0, 32'h0000_0000},
        {OFF_EN,   32'h0000_0015, 32'h0000_0015},
        {OFF_EN,   32'h0000_0000, 32'h0000_0000},
        {OFF_ALA,  32'h0000_0000, 32'h0000_0000},
        {OFF_ALB,  32'h0000_0000, 32'h0000_0000},
        {OFF_ALMS, 32'h0000_0000, 32'h0000_0000}
    };

    logic              clk;
    logic              rst_n;
    logic              tick_en;
    logic              bus_rd;
    logic              bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    int n_chk;
    int n_fail;
    bit done;

    bus_rtc #(
        .TICK_HZ    (TICK_HZ),
        .MS_PER_SEC (MS_PER_SEC),
        .COPY_TICKS (COPY_TICKS),
        .COPY_CYC   (COPY_CYC),
        .CD_W       (CD_W)
    ) u_bus_rtc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    initial begin
        clk = 1'b0;
        forever #5 clk = ~clk;
    end

    initial begin
        tick_en = 1'b0;
        forever begin
            repeat (TICK_GAP - 1) @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // Poll busy until one publish window opens and closes
    task automatic wait_window();
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = OFF_BUSY;
        @(negedge clk);
        while (bus_rdata[0] !== 1'b1) @(negedge clk);
        while (bus_rdata[0] !== 1'b0) @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic safe_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        wait_window();
        bwrite(a, d);
    endtask

    initial begin
        logic [31:0] rv;
        logic [31:0] s0;
        logic [31:0] s1;
        int rise0, rise1, width, cnt;
        logic prev;

        n_chk = 0; n_fail = 0; done = 1'b0;
        rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Register write/readback table (R12, accepted writes R3)
        for (int i = 0; i < NVEC; i++) begin
            if (i == 0) begin
                // R1: reset state before any write
                bread(OFF_SEC, rv);  check("R1 seconds", rv, 32'd0);
                bread(OFF_STAT, rv); check("R1 status", rv, 32'd0);
                bread(OFF_EN, rv);   check("R1 enable", rv, 32'd0);
                bread(OFF_BUSY, rv); check("R1 busy", rv, 32'd0);
                check("R1 irq", {31'd0, irq}, 32'd0);
            end
            safe_write(VECS[i][71:64], VECS[i][63:32]);
            bread(VECS[i][71:64], rv);
            check("R12 readback", rv, VECS[i][31:0]);
        end

        // R2: publish cadence and busy width
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = OFF_BUSY;
        rise0 = -1; rise1 = -1; width = 0; prev = 1'b0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (bus_rdata[0] && !prev) begin
                if (rise0 < 0) rise0 = c; else if (rise1 < 0) rise1 = c;
            end
            if (bus_rdata[0] && rise1 < 0 && rise0 >= 0) width++;
            prev = bus_rdata[0];
        end
        bus_rd = 1'b0;
        check("R2 period", 32'(rise1 - rise0), 32'(COPY_TICKS * TICK_GAP));
        check("R2 width", 32'(width), 32'(COPY_CYC));

        // R3: enable write landing inside the busy window is dropped
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = OFF_BUSY;
        @(negedge clk);
        while (bus_rdata[0] !== 1'b1) @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = OFF_EN; bus_wdata = 32'h1F;
        @(negedge clk);
        bus_wr = 1'b0;
        wait_window();
        bread(OFF_EN, rv);
        check("R3 dropped write", rv, 32'd0);

        // R10: seconds load is visible at once, milliseconds zeroed
        safe_write(OFF_SEC, 32'd100);
        bread(OFF_SEC, rv); check("R10 seconds", rv, 32'd100);
        bread(OFF_MS, rv);  check("R10 ms zero", rv, 32'd0);

        // R4: capture matches seconds, then holds while seconds move
        wait_window();
        bread(OFF_MS, rv);
        bread(OFF_CAPT, s0);
        bread(OFF_SEC, rv);
        check("R4 coherent", s0, rv);
        repeat (3) wait_window();
        bread(OFF_CAPT, rv);
        check("R4 capture held", rv, s0);
        bread(OFF_SEC, s1);
        check("R4 seconds advanced", 32'((s1 - s0 == 1) || (s1 - s0 == 2)), 32'd1);
        wait_window();
        bread(OFF_MS, rv);
        bread(OFF_CAPT, s0);
        bread(OFF_SEC, rv);
        check("R4 recapture", s0, rv);

        // R8/R9: seconds rollover, zero alarm stays silent
        safe_write(OFF_SEC, 32'hFFFF_FFFF);
        repeat (4) wait_window();
        bread(OFF_SEC, rv);  check("R8 rollover", rv, 32'd0);
        bread(OFF_MS, rv);   check("R8 ms range", 32'(rv < MS_PER_SEC), 32'd1);
        bread(OFF_STAT, rv); check("R9 zero alarm silent", rv, 32'd0);

        // R9/R5/R7: seconds alarm A fires on the match, not earlier
        safe_write(OFF_SEC, 32'd10);
        safe_write(OFF_ALA, 32'd12);
        safe_write(OFF_EN, 32'h01);
        bread(OFF_STAT, rv); check("R9 no early fire", rv, 32'd0);
        wait_window();
        bread(OFF_STAT, rv); check("R9 no fire at 11", rv, 32'd0);
        cnt = 0;
        while (!irq && cnt < 400) begin @(negedge clk); cnt++; end
        check("R7 irq on alarm", {31'd0, irq}, 32'd1);
        bread(OFF_STAT, rv); check("R5 alarm A bit", rv, 32'h01);

        // R6/R7: clear semantics and enable gating
        safe_write(OFF_STAT, 32'h0);
        bread(OFF_STAT, rv); check("R6 zero write keeps", rv, 32'h01);
        safe_write(OFF_EN, 32'h0);
        @(negedge clk);
        check("R7 irq masked", {31'd0, irq}, 32'd0);
        safe_write(OFF_EN, 32'h01);
        @(negedge clk);
        check("R7 irq re-enabled", {31'd0, irq}, 32'd1);
        safe_write(OFF_STAT, 32'h01);
        bread(OFF_STAT, rv); check("R6 one write clears", rv, 32'd0);
        check("R7 irq low after clear", {31'd0, irq}, 32'd0);
        safe_write(OFF_EN, 32'h0);
        safe_write(OFF_ALA, 32'h0);

        // R9/R5: milliseconds alarm
        safe_write(OFF_ALMS, 32'd5);
        repeat (3) wait_window();
        bread(OFF_STAT, rv); check("R5 ms alarm bit", rv, 32'h04);
        safe_write(OFF_ALMS, 32'd0);
        safe_write(OFF_STAT, 32'h04);
        bread(OFF_STAT, rv); check("R6 ms clear", rv, 32'd0);

        // R11: seconds countdown of 2
        safe_write(OFF_CDS, 32'd2);
        bread(OFF_STAT, rv); check("R11 seconds cd pending", rv, 32'd0);
        wait_window();
        bread(OFF_STAT, rv); check("R11 seconds cd not yet", rv, 32'd0);
        repeat (5) wait_window();
        bread(OFF_STAT, rv); check("R11 seconds cd expired", rv, 32'h08);
        safe_write(OFF_STAT, 32'h08);

        // R11: milliseconds countdown of 3
        safe_write(OFF_CDMS, 32'd3);
        bread(OFF_STAT, rv); check("R11 ms cd pending", rv, 32'd0);
        wait_window();
        bread(OFF_STAT, rv); check("R11 ms cd expired", rv, 32'h10);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule